// File: doc/BRIEF.md
# Multiply-Accumulate Engine with Sticky Overflow

This block holds a 64-bit accumulator as two 32-bit halves and adds one product into it per cycle. Each accumulate command multiplies a 32-bit register operand by an 8-bit immediate. The command selects one of six forms: word, half or byte width, each signed or unsigned. The product is added in two 32-bit steps. The low half is added first, and its carry is passed on to the high-half add. Overflow is judged on the high-half add alone. Once set, it is held in a sticky flag.

An extract command reports the flag state. It copies the sticky flag into a V output and clears a C output. With a saturation selector, it also returns the accumulator clamped to a signed 32-bit value. Software loads or clears the accumulator through direct write strobes and a synchronous clear. Instruction decode is done outside the block.

Top module: `sticky_mac`

## Requirements
- R1: While rst_ni is low, hi_o, lo_o, ovf_o, flag_v_o, flag_c_o and ext_data_o are all zero.
- R2: A high clr_i zeroes hi_o, lo_o and ovf_o on the next edge. It overrides writes and accumulates in the same cycle.
- R3: wr_hi_i and wr_lo_i load wr_data_i into the high or low half, and wr_ovf_i loads wr_data_i[0] into the sticky flag. Any write in a cycle cancels the accumulate of that cycle. With no command at all, the state holds.
- R4: An accumulate sets lo_o to lo + product[31:0] mod 2^32 on the next edge. The carry out of that add is 1 when the 32-bit sum is smaller than an addend. hi_o becomes hi + product[63:32] + carry. flag_c_o takes the carry.
- R5: An accumulate sets ovf_o when the old hi and product[63:32] agree in bit 31 and the new hi differs from them in bit 31.
- R6: An accumulate never clears ovf_o. Only clr_i or wr_ovf_i can lower it.
- R7: Mode 0 (signed word) multiplies the signed 32-bit operand by the sign-extended immediate. Mode 1 (unsigned word) zero-extends both operands.
- R8: Modes 2 and 3 use operand bits [7:0], and modes 4 and 5 use operand bits [15:0]. The even modes are signed, with the operand and immediate sign-extended. The odd modes are unsigned, with both zero-extended.
- R9: An accumulate with mode 6 or 7 has no effect on hi_o, lo_o, ovf_o or flag_c_o.
- R10: An extract sets flag_v_o to the pre-edge ovf_o and clears flag_c_o. This takes priority over a carry from a same-cycle accumulate. The extract reads the accumulator as it stood before that edge.
- R11: An extract with ext_sel_i = 0x20 sets ext_data_o to the signed 64-bit {hi,lo}, clamped to 0x80000000..0x7FFFFFFF. An extract with any other selector leaves ext_data_o unchanged.
- R12: An accumulate is accepted every cycle, and back-to-back commands each take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of the accumulator and sticky flag |
| wr_hi_i | input | 1 | Load high half from wr_data_i |
| wr_lo_i | input | 1 | Load low half from wr_data_i |
| wr_ovf_i | input | 1 | Load sticky flag from wr_data_i[0] |
| wr_data_i | input | 32 | Write data |
| acc_valid_i | input | 1 | Accumulate command |
| acc_mode_i | input | 3 | Form: 0 sw, 1 uw, 2 sb, 3 ub, 4 sh, 5 uh |
| operand_i | input | 32 | Register operand |
| imm_i | input | 8 | Immediate operand |
| ext_valid_i | input | 1 | Extract command |
| ext_sel_i | input | 8 | Extract selector (0x20 = saturate) |
| hi_o | output | 32 | Accumulator high half |
| lo_o | output | 32 | Accumulator low half |
| ovf_o | output | 1 | Sticky overflow flag |
| flag_v_o | output | 1 | V flag from last extract |
| flag_c_o | output | 1 | C flag |
| ext_data_o | output | 32 | Saturated extract result |

## Verification
A bad carry between the halves shows up in hi_o one edge after the accumulate that wraps the low half. Any operand extension fault corrupts hi_o or lo_o on that same edge. A sticky flag that drops or fails to set shows on ovf_o at once. It also shows on flag_v_o after the next extract. A clamp fault appears on ext_data_o one edge after a 0x20 extract. Because all state is visible every cycle, the bench compares every output after every edge. A wrong state is caught within one cycle of its cause.

// File: rtl/sticky_mac_pkg.sv
package sticky_mac_pkg;
  typedef enum logic [2:0] {
    MODE_SW = 3'd0,
    MODE_UW = 3'd1,
    MODE_SB = 3'd2,
    MODE_UB = 3'd3,
    MODE_SH = 3'd4,
    MODE_UH = 3'd5
  } mac_mode_e;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned HALF_W = 16;

  function automatic logic mode_ok(input logic [2:0] m);
    return m <= 3'd5;
  endfunction
endpackage

// File: rtl/mac_operand_prep.sv
module mac_operand_prep
  import sticky_mac_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IMM_W  = 8,
  localparam int unsigned AW = DATA_W + 1,
  localparam int unsigned BW = IMM_W + 1
) (
  input  logic [2:0]        mode_i,
  input  logic [DATA_W-1:0] op_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic [AW-1:0]     a_o,
  output logic [BW-1:0]     b_o
);
  logic signed_form;

  always_comb begin
    signed_form = 1'b0;
    a_o = '0;
    unique case (mode_i)
      MODE_SW: begin
        signed_form = 1'b1;
        a_o = {op_i[DATA_W-1], op_i};
      end
      MODE_UW: a_o = {1'b0, op_i};
      MODE_SB: begin
        signed_form = 1'b1;
        a_o = {{(AW-BYTE_W){op_i[BYTE_W-1]}}, op_i[BYTE_W-1:0]};
      end
      MODE_UB: a_o = {{(AW-BYTE_W){1'b0}}, op_i[BYTE_W-1:0]};
      MODE_SH: begin
        signed_form = 1'b1;
        a_o = {{(AW-HALF_W){op_i[HALF_W-1]}}, op_i[HALF_W-1:0]};
      end
      MODE_UH: a_o = {{(AW-HALF_W){1'b0}}, op_i[HALF_W-1:0]};
      default: a_o = '0;
    endcase
    b_o = {signed_form & imm_i[IMM_W-1], imm_i};
  end
endmodule

// File: rtl/mac_split_adder.sv
module mac_split_adder #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IMM_W  = 8,
  localparam int unsigned AW = DATA_W + 1,
  localparam int unsigned BW = IMM_W + 1,
  localparam int unsigned PW = AW + BW
) (
  input  logic [AW-1:0]     a_i,
  input  logic [BW-1:0]     b_i,
  input  logic [DATA_W-1:0] hi_i,
  input  logic [DATA_W-1:0] lo_i,
  output logic [DATA_W-1:0] hi_o,
  output logic [DATA_W-1:0] lo_o,
  output logic              carry_o,
  output logic              ovf_o
);
  logic signed [PW-1:0]       prod_s;
  logic [2*DATA_W-1:0]        prod_full;
  logic [DATA_W:0]            lo_sum;
  logic [DATA_W-1:0]          p_hi;

  // narrow signed multiply, then sign-extend to the accumulator width
  assign prod_s    = $signed(a_i) * $signed(b_i);
  assign prod_full = {{(2*DATA_W-PW){prod_s[PW-1]}}, prod_s};
  assign p_hi      = prod_full[2*DATA_W-1:DATA_W];

  assign lo_sum  = {1'b0, lo_i} + {1'b0, prod_full[DATA_W-1:0]};
  assign carry_o = lo_sum[DATA_W];
  assign lo_o    = lo_sum[DATA_W-1:0];
  assign hi_o    = hi_i + p_hi + {{(DATA_W-1){1'b0}}, carry_o};
  assign ovf_o   = (hi_i[DATA_W-1] == p_hi[DATA_W-1]) &&
                   (hi_o[DATA_W-1] != p_hi[DATA_W-1]);
endmodule

// File: rtl/mac_saturate.sv
module mac_saturate #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] hi_i,
  input  logic [DATA_W-1:0] lo_i,
  output logic [DATA_W-1:0] sat_o
);
  localparam logic [2*DATA_W-1:0] POS_LIM = {{(DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic [2*DATA_W-1:0] NEG_LIM = {{(DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};

  logic [2*DATA_W-1:0] acc;
  assign acc = {hi_i, lo_i};

  always_comb begin
    if ($signed(acc) > $signed(POS_LIM))      sat_o = {1'b0, {(DATA_W-1){1'b1}}};
    else if ($signed(acc) < $signed(NEG_LIM)) sat_o = {1'b1, {(DATA_W-1){1'b0}}};
    else                                      sat_o = lo_i;
  end
endmodule

// File: rtl/sticky_mac.sv
module sticky_mac
  import sticky_mac_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned IMM_W    = 8,
  parameter int unsigned SEL_W    = 8,
  parameter logic [7:0]  SAT_CODE = 8'h20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_hi_i,
  input  logic              wr_lo_i,
  input  logic              wr_ovf_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              acc_valid_i,
  input  logic [2:0]        acc_mode_i,
  input  logic [DATA_W-1:0] operand_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              ext_valid_i,
  input  logic [SEL_W-1:0]  ext_sel_i,
  output logic [DATA_W-1:0] hi_o,
  output logic [DATA_W-1:0] lo_o,
  output logic              ovf_o,
  output logic              flag_v_o,
  output logic              flag_c_o,
  output logic [DATA_W-1:0] ext_data_o
);
  localparam int unsigned AW = DATA_W + 1;
  localparam int unsigned BW = IMM_W + 1;

  logic [AW-1:0]     a_ext;
  logic [BW-1:0]     b_ext;
  logic [DATA_W-1:0] hi_sum, lo_sum, sat_val;
  logic              carry, add_ovf;
  logic              any_wr, do_acc;

  mac_operand_prep #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_prep (
    .mode_i(acc_mode_i), .op_i(operand_i), .imm_i(imm_i),
    .a_o(a_ext), .b_o(b_ext)
  );

  mac_split_adder #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_add (
    .a_i(a_ext), .b_i(b_ext), .hi_i(hi_o), .lo_i(lo_o),
    .hi_o(hi_sum), .lo_o(lo_sum), .carry_o(carry), .ovf_o(add_ovf)
  );

  mac_saturate #(.DATA_W(DATA_W)) u_sat (
    .hi_i(hi_o), .lo_i(lo_o), .sat_o(sat_val)
  );

  assign any_wr = wr_hi_i | wr_lo_i | wr_ovf_i;
  assign do_acc = acc_valid_i & mode_ok(acc_mode_i) & ~clr_i & ~any_wr;

  // accumulator and sticky flag: clear > writes > accumulate
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_o  <= '0;
      lo_o  <= '0;
      ovf_o <= 1'b0;
    end else if (clr_i) begin
      hi_o  <= '0;
      lo_o  <= '0;
      ovf_o <= 1'b0;
    end else if (any_wr) begin
      if (wr_hi_i)  hi_o  <= wr_data_i;
      if (wr_lo_i)  lo_o  <= wr_data_i;
      if (wr_ovf_i) ovf_o <= wr_data_i[0];
    end else if (do_acc) begin
      hi_o  <= hi_sum;
      lo_o  <= lo_sum;
      ovf_o <= ovf_o | add_ovf;
    end
  end

  // flags and extract result
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_v_o   <= 1'b0;
      flag_c_o   <= 1'b0;
      ext_data_o <= '0;
    end else begin
      if (ext_valid_i) begin
        flag_v_o <= ovf_o;
        flag_c_o <= 1'b0;
        if (ext_sel_i == SEL_W'(SAT_CODE)) ext_data_o <= sat_val;
      end else if (do_acc) begin
        flag_c_o <= carry;
      end
    end
  end

  p_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (hi_o == '0) && (lo_o == '0) && !ovf_o);

  p_idle_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i && !any_wr && !acc_valid_i |=> $stable(hi_o) && $stable(lo_o) && $stable(ovf_o));

  p_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o && !clr_i && !wr_ovf_i |=> ovf_o);

  p_bad_mode_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && (acc_mode_i > 3'd5) && !clr_i && !any_wr
    |=> $stable(hi_o) && $stable(lo_o) && $stable(ovf_o));

  p_ext_flags_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_valid_i |=> !flag_c_o && (flag_v_o == $past(ovf_o)));

  p_sat_inrange_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_valid_i && (ext_sel_i == SEL_W'(SAT_CODE)) && (hi_o == '0) && !lo_o[DATA_W-1]
    |=> ext_data_o == $past(lo_o));

  p_sel_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_sel_i != SEL_W'(SAT_CODE) |=> $stable(ext_data_o));
endmodule

// File: tb/sticky_mac_bench.sv
module sticky_mac_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        clr, whi, wlo, wov, accv, extv;
  logic [31:0] wdata, op;
  logic [2:0]  mode;
  logic [7:0]  imm, sel;
  logic [31:0] hi, lo, edata;
  logic        ovf, fv, fc;

  sticky_mac u_sticky_mac (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .wr_hi_i(whi), .wr_lo_i(wlo),
    .wr_ovf_i(wov), .wr_data_i(wdata), .acc_valid_i(accv), .acc_mode_i(mode),
    .operand_i(op), .imm_i(imm), .ext_valid_i(extv), .ext_sel_i(sel),
    .hi_o(hi), .lo_o(lo), .ovf_o(ovf), .flag_v_o(fv), .flag_c_o(fc),
    .ext_data_o(edata)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] m_hi = 0, m_lo = 0, m_data = 0;
  logic        m_ovf = 0, m_v = 0, m_c = 0;

  function automatic logic [63:0] exp_prod(input logic [2:0] md, input logic [31:0] a,
                                            input logic [7:0] b);
    longint x, y;
    case (md)
      3'd0: begin x = longint'($signed(a));       y = longint'($signed(b)); end
      3'd1: begin x = longint'(a);                y = longint'(b);          end
      3'd2: begin x = longint'($signed(a[7:0]));  y = longint'($signed(b)); end
      3'd3: begin x = longint'(a[7:0]);           y = longint'(b);          end
      3'd4: begin x = longint'($signed(a[15:0])); y = longint'($signed(b)); end
      default: begin x = longint'(a[15:0]);       y = longint'(b);          end
    endcase
    return 64'(x * y);
  endfunction

  function automatic logic [31:0] exp_sat(input logic [31:0] h, input logic [31:0] l);
    longint s;
    s = longint'({h, l});
    if (s > 64'sd2147483647) return 32'h7FFFFFFF;
    if (s < -64'sd2147483648) return 32'h80000000;
    return l;
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag, "hi", hi, m_hi);
    chk(tag, "lo", lo, m_lo);
    chk(tag, "ovf", {31'd0, ovf}, {31'd0, m_ovf});
    chk(tag, "v", {31'd0, fv}, {31'd0, m_v});
    chk(tag, "c", {31'd0, fc}, {31'd0, m_c});
    chk(tag, "ext", edata, m_data);
  endtask

  // called at negedge; drives, steps one edge, updates model, compares at next negedge
  task automatic step(input logic c_clr, input logic c_whi, input logic c_wlo,
                      input logic c_wov, input logic [31:0] c_wd, input logic c_acc,
                      input logic [2:0] c_md, input logic [31:0] c_op, input logic [7:0] c_imm,
                      input logic c_ext, input logic [7:0] c_sel, input string tag);
    logic [63:0] p;
    logic [32:0] ls;
    logic [31:0] nh;
    logic        cy, vv, did;
    clr = c_clr; whi = c_whi; wlo = c_wlo; wov = c_wov; wdata = c_wd;
    accv = c_acc; mode = c_md; op = c_op; imm = c_imm; extv = c_ext; sel = c_sel;
    @(posedge clk);
    p   = exp_prod(c_md, c_op, c_imm);
    ls  = {1'b0, m_lo} + {1'b0, p[31:0]};
    cy  = ls[32];
    nh  = m_hi + p[63:32] + {31'd0, cy};
    vv  = (m_hi[31] == p[63]) && (nh[31] != p[63]);
    did = c_acc && (c_md <= 3'd5) && !c_clr && !(c_whi || c_wlo || c_wov);
    if (c_ext) begin
      m_v = m_ovf;
      if (c_sel == 8'h20) m_data = exp_sat(m_hi, m_lo);
    end
    if (c_clr) begin
      m_hi = 0; m_lo = 0; m_ovf = 0;
    end else if (c_whi || c_wlo || c_wov) begin
      if (c_whi) m_hi = c_wd;
      if (c_wlo) m_lo = c_wd;
      if (c_wov) m_ovf = c_wd[0];
    end else if (did) begin
      m_hi = nh; m_lo = ls[31:0]; m_ovf = m_ovf | vv;
    end
    if (c_ext) m_c = 1'b0;
    else if (did) m_c = cy;
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic load(input logic [31:0] h, input logic [31:0] l, input string tag);
    step(0, 1, 0, 0, h, 0, 0, 0, 0, 0, 0, tag);
    step(0, 0, 1, 0, l, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic accum(input logic [2:0] md, input logic [31:0] a, input logic [7:0] b,
                       input string tag);
    step(0, 0, 0, 0, 0, 1, md, a, b, 0, 0, tag);
  endtask

  task automatic extract(input logic [7:0] s, input string tag);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, s, tag);
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    {clr, whi, wlo, wov, accv, extv} = '0;
    wdata = 0; op = 0; mode = 0; imm = 0; sel = 0;
    repeat (3) @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");

    // R3 direct writes, write cancels accumulate
    load(32'h1234_5678, 32'h9ABC_DEF0, "R3");
    step(0, 0, 0, 1, 32'h1, 0, 0, 0, 0, 0, 0, "R3");
    step(0, 0, 0, 1, 32'h0, 1, 1, 32'h5, 8'h5, 0, 0, "R3");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R3");

    // R4 carry from low into high
    load(32'h0000_0010, 32'hFFFF_FFFF, "R4");
    accum(1, 32'h1, 8'h1, "R4");
    accum(1, 32'h8000_0000, 8'h4, "R4");

    // R5 overflow, R6 sticky, R2 clear
    load(32'h7FFF_FFFF, 32'h0, "R5");
    accum(0, 32'h7FFF_FFFF, 8'h7F, "R5");
    accum(1, 32'h3, 8'h2, "R6");
    accum(0, 32'hFFFF_FFFF, 8'h01, "R6");
    extract(8'h00, "R10");
    step(1, 1, 1, 1, 32'hFFFF_FFFF, 1, 0, 32'h7, 8'h7, 0, 0, "R2");

    // R7 word forms
    accum(0, 32'hFFFF_FFFF, 8'hFF, "R7");
    accum(1, 32'hFFFF_FFFF, 8'hFF, "R7");
    accum(0, 32'h8000_0000, 8'h80, "R7");

    // R8 byte and half forms
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
    accum(2, 32'h1234_56FF, 8'h02, "R8");
    accum(3, 32'h1234_56FF, 8'h02, "R8");
    accum(4, 32'h1234_FFFE, 8'h03, "R8");
    accum(5, 32'h1234_FFFE, 8'h03, "R8");
    accum(2, 32'hFFFF_FF80, 8'h80, "R8");
    accum(5, 32'hFFFF_FFFF, 8'hFF, "R8");

    // R9 undefined modes
    accum(6, 32'hFFFF_FFFF, 8'hFF, "R9");
    accum(7, 32'h1234_5678, 8'h81, "R9");

    // R10/R11 extract, saturation
    load(32'h0000_0001, 32'h0, "R11");
    extract(8'h20, "R11");
    load(32'hFFFF_FFFE, 32'h1234_5678, "R11");
    extract(8'h20, "R11");
    load(32'hFFFF_FFFF, 32'h8000_0000, "R11");
    extract(8'h20, "R11");
    load(32'h0, 32'h7FFF_FFFF, "R11");
    extract(8'h20, "R11");
    extract(8'h21, "R11");
    load(32'h0, 32'hFFFF_FFFF, "R10");
    step(0, 0, 0, 0, 0, 1, 1, 32'h1, 8'h1, 1, 8'h20, "R10");

    // R12 back-to-back accumulates
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R12");
    for (int i = 0; i < 8; i++) accum(3'(i % 6), 32'h0101_0101 * (i + 1), 8'(8'h11 * i), "R12");

    // constrained random mix
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[6:0] == 0, r[11:8] == 0, r[15:12] == 0, r[19:16] == 0, $urandom,
           r[22:20] != 0, 3'($urandom), (r[23] ? $urandom : $urandom & 32'hFF),
           8'($urandom), r[26:24] == 0, (r[27] ? 8'h20 : 8'($urandom)), "R4/R12");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule